// File: doc/BRIEF.md
# Nine-bit serial word packer for display command links

This block sits between a command/pixel byte source and an SPI master that can only shift 8-bit words. Each incoming byte carries a kind tag that marks it as display data, a command code or a flush request. The block turns every data or command byte into a 9-bit serial word. The leading bit of each word is the data/command flag (1 for data, 0 for a command), and the eight payload bits follow, most significant first. The words are then cut into a plain byte stream for the shifter.

Eight 9-bit words make up one 72-bit group, which leaves as exactly nine bytes. A command always starts a fresh group. The command code fills the last word of its group, and seven zero (no-operation) words come before it. A data group may stop early, either because a flush token arrives or because a command is due. In that case the group is completed with zero bits after its last word. For 16-bit pixels, the source supplies the high byte before the low byte, and the block sends bytes in the order they arrive.

Top module: `dbi9_packer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the first data byte accepted opens a new group.
- R2: Data byte k of a group (k = 0..7), with kind 2'b00, is sent as word {1, byte}, so output byte k carries the flag 1 at bit 7-k, followed by the byte's upper 7-k bits; the bit stream is continuous, most significant bit first.
- R3: Eight data bytes yield exactly nine output bytes; the ninth carries the low eight bits of the eighth word, and in_ready stays low while it is produced.
- R4: A command byte (kind 2'b01) accepted at a group boundary produces eight zero bytes followed by the command code.
- R5: A command accepted while a data group is partly filled first completes that group with zero bits to nine bytes, then emits its own nine-byte command group.
- R6: A flush token (kind 2'b10 or 2'b11; its byte value is ignored) with a partly filled data group completes the group with zero bits so that the group totals nine bytes.
- R7: A flush token at a group boundary produces no output byte and leaves the group position at zero.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_byte does not change.
- R9: When out_ready is held high, a data byte that is accepted appears as out_valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Block accepts the token this cycle |
| in_kind | input | 2 | 2'b00 data, 2'b01 command, 2'b1x flush |
| in_byte | input | DW | Data byte or command code |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Shifter takes the output byte |
| out_byte | output | DW | Packed output byte |

## Verification
The assertions take for granted that the source holds in_valid, in_kind and in_byte steady until the token is taken, and that out_ready may change freely from cycle to cycle. The bench drives each token once, keeps it unchanged until it sees in_ready, and changes inputs only just after a clock edge. A pseudo-random out_ready pattern exercises the hold rule under backpressure. A bit-level model in the bench builds the expected byte stream from the data words, the zero padding and the command groups, and the bench compares that stream byte by byte with the output.

// File: rtl/dbi9_pkg.sv
package dbi9_pkg;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_PAD  = 2'd1,
    SQ_LEAD = 2'd2
  } seq_state_e;

  localparam logic [1:0] KIND_DATA = 2'b00;
  localparam logic [1:0] KIND_CMD  = 2'b01;

endpackage

// File: rtl/dbi9_rst_sync.sv
module dbi9_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/dbi9_seq.sv
module dbi9_seq
  import dbi9_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_kind,
  input  logic [DW-1:0]   in_byte,
  input  logic [PH_W-1:0] phase,
  input  logic            slot_free,
  output logic            in_ready,
  output logic            step,
  output logic            word_dc,
  output logic [DW-1:0]   word_val,
  output seq_state_e      state
);

  localparam logic [PH_W-1:0] PH_FULL = PH_W'(DW);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DW - 1);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] cmd_q, cmd_d;
  logic          pend_q, pend_d;
  logic          cmd_en, pend_en;
  logic          phase_full, phase_zero;

  assign phase_full = (phase == PH_FULL);
  assign phase_zero = (phase == '0);

  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    pend_d   = pend_q;
    cmd_en   = 1'b0;
    pend_en  = 1'b0;
    in_ready = 1'b0;
    step     = 1'b0;
    word_dc  = 1'b0;
    word_val = '0;
    case (state_q)
      SQ_RUN: begin
        if (phase_full) begin
          step = slot_free;
        end else begin
          in_ready = slot_free;
          if (in_valid && slot_free) begin
            if (in_kind == KIND_DATA) begin
              step     = 1'b1;
              word_dc  = 1'b1;
              word_val = in_byte;
            end else if (in_kind == KIND_CMD) begin
              cmd_d   = in_byte;
              cmd_en  = 1'b1;
              pend_d  = !phase_zero;
              pend_en = 1'b1;
              state_d = phase_zero ? SQ_LEAD : SQ_PAD;
            end else if (!phase_zero) begin
              pend_d  = 1'b0;
              pend_en = 1'b1;
              state_d = SQ_PAD;
            end
          end
        end
      end
      SQ_PAD: begin
        step = slot_free;
        if (step && phase_full) begin
          state_d = pend_q ? SQ_LEAD : SQ_RUN;
          pend_d  = 1'b0;
          pend_en = 1'b1;
        end
      end
      SQ_LEAD: begin
        step = slot_free;
        if (phase == PH_LAST) word_val = cmd_q;
        if (step && phase_full) state_d = SQ_RUN;
      end
      default: state_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      cmd_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_en)  cmd_q  <= cmd_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/dbi9_shift.sv
module dbi9_shift #(
  parameter int DW   = 8,
  parameter int PH_W = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            word_dc,
  input  logic [DW-1:0]   word_val,
  output logic [PH_W-1:0] phase,
  output logic [DW-1:0]   byte_nx
);

  localparam int              CW      = 2 * DW;
  localparam logic [PH_W-1:0] PH_FULL = PH_W'(DW);

  logic [DW-1:0]   carry_q, carry_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [CW-1:0]   word_al, merged;

  always_comb begin
    word_al = {word_dc, word_val, {(DW-1){1'b0}}};
    merged  = {carry_q, {DW{1'b0}}} | (word_al >> phase_q);
    if (phase_q == PH_FULL) begin
      byte_nx = carry_q;
      carry_d = '0;
      phase_d = '0;
    end else begin
      byte_nx = merged[CW-1:DW];
      carry_d = merged[DW-1:0];
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= '0;
      phase_q <= '0;
    end else if (step) begin
      carry_q <= carry_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/dbi9_obuf.sv
module dbi9_obuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] byte_nx,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_byte,
  output logic          slot_free
);

  logic          valid_q, valid_d;
  logic [DW-1:0] byte_q;

  assign slot_free = !valid_q || out_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) byte_q <= byte_nx;
    end
  end

  assign out_valid = valid_q;
  assign out_byte  = byte_q;

endmodule

// File: rtl/dbi9_packer.sv
module dbi9_packer
  import dbi9_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic [DW-1:0] in_byte,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_byte
);

  localparam int PH_W = $clog2(DW + 1);

  logic            rst_n_s;
  logic [PH_W-1:0] phase_w;
  logic            slot_free_w;
  logic            step_w;
  logic            word_dc_w;
  logic [DW-1:0]   word_val_w;
  logic [DW-1:0]   byte_nx_w;
  seq_state_e      state_w;

  dbi9_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dbi9_seq #(.DW(DW), .PH_W(PH_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .in_byte   (in_byte),
    .phase     (phase_w),
    .slot_free (slot_free_w),
    .in_ready  (in_ready),
    .step      (step_w),
    .word_dc   (word_dc_w),
    .word_val  (word_val_w),
    .state     (state_w)
  );

  dbi9_shift #(.DW(DW), .PH_W(PH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step     (step_w),
    .word_dc  (word_dc_w),
    .word_val (word_val_w),
    .phase    (phase_w),
    .byte_nx  (byte_nx_w)
  );

  dbi9_obuf #(.DW(DW)) u_obuf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (step_w),
    .byte_nx   (byte_nx_w),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .slot_free (slot_free_w)
  );

endmodule

// File: rtl/dbi9_packer_chk.sv
module dbi9_packer_chk
  import dbi9_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = $clog2(DW + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_kind,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_byte,
  input logic [PH_W-1:0] phase,
  input seq_state_e      state,
  input logic            step
);

  localparam logic [PH_W-1:0] PH_FULL = PH_W'(DW);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DW - 1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_FULL);

  assert_tail_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FULL) |-> !in_ready);

  assert_data_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == KIND_DATA) |=> out_valid);

  assert_lead_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LEAD && step && phase < PH_LAST) |=> (out_byte == '0));

  assert_flush_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind[1] && phase == '0) |=> (phase == '0));

endmodule

bind dbi9_packer dbi9_packer_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_kind   (in_kind),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte),
  .phase     (phase_w),
  .state     (state_w),
  .step      (step_w)
);

// File: tb/sim_dbi9_packer.sv
module sim_dbi9_packer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [1:0] in_kind;
  logic [7:0] in_byte;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;

  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  bit         exp_bits[$];
  int         wcnt = 0;
  bit         bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_byte = 8'h00;

  always #5 clk = ~clk;

  dbi9_packer #(.DW(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // out_ready driver: steady high, or pseudo-random under backpressure
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // monitor sampled mid-cycle; R8 hold checked on every stalled cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) check(out_valid && out_byte == prev_byte, "R8 hold",
                            {out_valid, out_byte}, {1'b1, prev_byte});
      if (out_valid && out_ready) got_q.push_back(out_byte);
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // reference model of the serial bit stream
  task automatic m_word(bit dc, logic [7:0] v);
    exp_bits.push_back(dc);
    for (int i = 7; i >= 0; i--) exp_bits.push_back(v[i]);
    wcnt = (wcnt + 1) % 8;
  endtask

  task automatic m_pad();
    while (wcnt != 0) m_word(1'b0, 8'h00);
  endtask

  task automatic m_cmd(logic [7:0] c);
    m_pad();
    repeat (7) m_word(1'b0, 8'h00);
    m_word(1'b0, c);
  endtask

  task automatic m_collect();
    while (exp_bits.size() >= 8) begin
      logic [7:0] b;
      for (int i = 7; i >= 0; i--) b[i] = exp_bits.pop_front();
      exp_q.push_back(b);
    end
  endtask

  task automatic send(logic [1:0] kind, logic [7:0] v);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_kind  = kind;
    in_byte  = v;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_byte  = 8'hxx;
    if (kind == 2'b00)      m_word(1'b1, v);
    else if (kind == 2'b01) m_cmd(v);
    else                    m_pad();
  endtask

  task automatic compare(string req);
    repeat (60) @(posedge clk);
    m_collect();
    check(got_q.size() == exp_q.size(), {req, " length"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
  endtask

  task automatic clear();
    got_q.delete();
    exp_q.delete();
    exp_bits.delete();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_single();
    send(2'b00, 8'hA5);
    send(2'b11, 8'hFF);
    compare("R6 partial group padded");
    check(got_q.size() > 1 && got_q[0] == 8'hD2, "R2 first byte flag", got_q[0], 8'hD2);
    check(got_q.size() > 1 && got_q[1] == 8'h80, "R2 second byte carry", got_q[1], 8'h80);
    check(got_q.size() == 9, "R6 group size", got_q.size(), 9);
    clear();
  endtask

  task automatic t_full();
    for (int i = 1; i <= 8; i++) send(2'b00, 8'(i * 17));
    compare("R3 full group");
    check(got_q.size() == 9, "R3 nine bytes", got_q.size(), 9);
    check(got_q.size() == 9 && got_q[8] == 8'h88, "R3 ninth byte", got_q[8], 8'h88);
    clear();
  endtask

  task automatic t_cmd();
    send(2'b01, 8'h2C);
    compare("R4 command group");
    check(got_q.size() == 9 && got_q[8] == 8'h2C, "R4 command last", got_q[8], 8'h2C);
    check(got_q.size() == 9 && got_q[0] == 8'h00, "R4 leading zero", got_q[0], 0);
    clear();
  endtask

  task automatic t_cmd_mid();
    send(2'b00, 8'h01);
    send(2'b00, 8'h02);
    send(2'b00, 8'h03);
    send(2'b01, 8'h2A);
    compare("R5 command after partial data");
    check(got_q.size() == 18 && got_q[17] == 8'h2A, "R5 command after pad", got_q[17], 8'h2A);
    clear();
  endtask

  task automatic t_flush_empty();
    send(2'b10, 8'hFF);
    repeat (20) @(posedge clk);
    check(got_q.size() == 0, "R7 flush at boundary", got_q.size(), 0);
    send(2'b00, 8'h5A);
    send(2'b10, 8'h00);
    compare("R7 group restarts at zero");
    clear();
  endtask

  task automatic t_stream_fast();
    send(2'b00, 8'hF0);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 byte one cycle after accept", out_valid, 1);
    send(2'b10, 8'h00);
    compare("R9 stream");
    clear();
  endtask

  task automatic t_backpressure();
    logic [7:0] v;
    bp_en = 1'b1;
    v = 8'h3C;
    for (int i = 0; i < 21; i++) begin
      v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
      send(2'b00, v);
    end
    send(2'b01, 8'h29);
    for (int i = 0; i < 5; i++) send(2'b00, 8'(8'hC3 + i));
    send(2'b10, 8'h00);
    repeat (100) @(posedge clk);
    compare("R8 stream under backpressure");
    bp_en = 1'b0;
    clear();
  endtask

  initial begin
    in_valid  = 1'b0;
    in_kind   = 2'b00;
    in_byte   = 8'h00;
    out_ready = 1'b1;
    t_reset();
    t_single();
    t_full();
    t_cmd();
    t_cmd_mid();
    t_flush_empty();
    t_stream_fast();
    t_backpressure();
    summary();
    $finish;
  end

endmodule